// File: doc/BRIEF.md
# Load Address and Extension Unit

This unit sits between a decoded memory instruction and a 64-bit data memory. For each request it forms the effective byte address from a base register, an offset register and an immediate. Four addressing modes are supported: scaled unsigned offset, register offset, pre-index and post-index. For the two index modes it also produces the updated base value and a write-back enable. For stores it places the low bytes of the source register on the correct byte lanes and raises a matching byte strobe. For loads it selects the addressed lanes of the returned memory word. It then zero-extends or sign-extends the value, and can clear the upper half of the result for a 32-bit destination.

Each request is accepted on a valid/ready handshake while the unit is idle. The unit then holds a single memory access until the memory raises ready. One cycle later it presents the result for exactly one cycle. Data is little-endian: the byte at address A sits in lane A mod 8 of the 64-bit memory word. Accesses are assumed to be naturally aligned.

Top module: `lsu_addr_ext`

## Requirements
- R1: Mode code 0 (scaled unsigned offset): the address is base + (immediate zero-extended, shifted left by the size code), where size codes are 0 byte, 1 halfword, 2 word, 3 doubleword. No write-back occurs.
- R2: Mode code 1 (register offset): the address is base + offset register. The immediate is ignored and no write-back occurs.
- R3: Mode code 2 (pre-index): the address and the write-back value both equal base + sign-extended immediate, and write-back is enabled.
- R4: Mode code 3 (post-index): the address equals the unmodified base, the write-back value is base + sign-extended immediate, and write-back is enabled.
- R5: An unsigned load of a byte, halfword or word returns the value zero-extended to 64 bits. A doubleword load returns the word unchanged.
- R6: A signed load of a byte, halfword or word returns the value sign-extended to 64 bits.
- R7: When the 32-bit destination flag is set, bits 63:32 of the load result are zero. Bits 31:0 still carry the extended value.
- R8: A store drives strobe bits lane..lane+n-1, where n is 1, 2, 4 or 8 bytes and lane is address bits 2:0. It places the low n source bytes on those lanes, drives zero on all other lanes, and asserts the write enable.
- R9: A load takes its data from byte lane (address mod 8) upward in the returned memory word.
- R10: A request is accepted only while ready is high. The memory request then stays asserted, with a stable address, strobe and data, until memory ready is seen. The response is valid for exactly one cycle, in the cycle after the memory handshake.
- R11: After reset the unit is ready for a request, with no memory request and no response pending.
- R12: A request presented while an access is in progress has no effect on that access or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_store | input | 1 | 1 store, 0 load |
| req_mode | input | 2 | Addressing mode code (0..3) |
| req_size | input | 2 | Access size code (0..3) |
| req_signed | input | 1 | Sign-extend load data |
| req_dst32 | input | 1 | 32-bit destination, clear bits 63:32 |
| req_base | input | 64 | Base register value |
| req_offset | input | 64 | Offset register value |
| req_imm | input | 12 | Immediate field |
| req_wsrc | input | 64 | Store source register value |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts and completes the access |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 64 | Effective byte address |
| mem_strb | output | 8 | Byte-lane write strobe |
| mem_wdata | output | 64 | Lane-aligned store data |
| mem_rdata | input | 64 | Memory word, valid with mem_ready |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_addr | output | 64 | Effective address of the access |
| resp_wb_en | output | 1 | Base write-back enable |
| resp_wb_val | output | 64 | Updated base value |
| resp_ld_data | output | 64 | Extended load result, zero for stores |

## Verification
The main path is tried with every addressing mode at several sizes. Scaled immediates at each size separate correct scaling from plain addition. Positive and negative pre- and post-index immediates show whether the sign extension and the choice of address (sum or plain base) are right. A register-offset case carries a nonzero immediate to show that field is ignored. A fixed memory word with both negative and positive bytes in known lanes is read at different lane offsets, in unsigned, signed and 32-bit-destination variants, so each extension rule produces a distinct value. Stores at four lane offsets and sizes expose strobe and data placement errors, and a stalled access with a competing request checks that the request is held and that the second request is ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      AM_UOFF = 2'd0,
      AM_ROFF = 2'd1,
      AM_PRE  = 2'd2,
      AM_POST = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } asize_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_RESP = 2'd2
   } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int IMM_W      = 12,
   parameter bit SCALE_UOFF = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] offs_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  amode_e            mode_i,
   input  asize_e            size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic [ADDR_W-1:0] wb_val_o,
   output logic              wb_en_o
);
   localparam int EXT_W = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] imm_z;
   logic [ADDR_W-1:0] imm_s;
   logic [ADDR_W-1:0] uoff_disp;
   logic [ADDR_W-1:0] idx_sum;

   assign imm_z = {{EXT_W{1'b0}}, imm_i};
   assign imm_s = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

   generate
      if (SCALE_UOFF) begin : g_scaled
         assign uoff_disp = imm_z << size_i;
      end else begin : g_unscaled
         assign uoff_disp = imm_z;
      end
   endgenerate

   assign idx_sum = base_i + imm_s;

   always_comb begin
      case (mode_i)
         AM_UOFF: ea_o = base_i + uoff_disp;
         AM_ROFF: ea_o = base_i + offs_i;
         AM_PRE:  ea_o = idx_sum;
         default: ea_o = base_i;
      endcase
   end

   assign wb_val_o = idx_sum;
   assign wb_en_o  = (mode_i == AM_PRE) || (mode_i == AM_POST);
endmodule

// File: rtl/lsu_st_fmt.sv
module lsu_st_fmt
   import lsu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = $clog2(DATA_W / 8)
) (
   input  logic [LANE_W-1:0]   lane_i,
   input  asize_e              size_i,
   input  logic [DATA_W-1:0]   src_i,
   output logic [DATA_W-1:0]   wdata_o,
   output logic [DATA_W/8-1:0] strb_o
);
   localparam int NB = DATA_W / 8;

   logic [NB-1:0]     size_mask;
   logic [DATA_W-1:0] src_trim;

   always_comb begin
      case (size_i)
         SZ_B:    size_mask = NB'(8'h01);
         SZ_H:    size_mask = NB'(8'h03);
         SZ_W:    size_mask = NB'(8'h0F);
         default: size_mask = '1;
      endcase
   end

   for (genvar b = 0; b < NB; b++) begin : g_trim
      assign src_trim[b*8 +: 8] = size_mask[b] ? src_i[b*8 +: 8] : 8'h00;
   end

   assign strb_o  = size_mask << lane_i;
   assign wdata_o = src_trim << {lane_i, 3'b000};
endmodule

// File: rtl/lsu_ld_fmt.sv
module lsu_ld_fmt
   import lsu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = $clog2(DATA_W / 8)
) (
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [LANE_W-1:0] lane_i,
   input  asize_e            size_i,
   input  logic              signed_i,
   input  logic              dst32_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] zx;
   logic [DATA_W-1:0] sx;
   logic [DATA_W-1:0] ext;

   assign sh = rdata_i >> {lane_i, 3'b000};

   always_comb begin
      case (size_i)
         SZ_B: begin
            zx = {{(DATA_W-8){1'b0}}, sh[7:0]};
            sx = {{(DATA_W-8){sh[7]}}, sh[7:0]};
         end
         SZ_H: begin
            zx = {{(DATA_W-16){1'b0}}, sh[15:0]};
            sx = {{(DATA_W-16){sh[15]}}, sh[15:0]};
         end
         SZ_W: begin
            zx = {{(DATA_W-32){1'b0}}, sh[31:0]};
            sx = {{(DATA_W-32){sh[31]}}, sh[31:0]};
         end
         default: begin
            zx = sh;
            sx = sh;
         end
      endcase
   end

   assign ext    = signed_i ? sx : zx;
   assign data_o = dst32_i ? {{HALF_W{1'b0}}, ext[HALF_W-1:0]} : ext;
endmodule

// File: rtl/lsu_addr_ext.sv
module lsu_addr_ext
   import lsu_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int DATA_W     = 64,
   parameter int IMM_W      = 12,
   parameter bit SCALE_UOFF = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_store,
   input  logic [1:0]          req_mode,
   input  logic [1:0]          req_size,
   input  logic                req_signed,
   input  logic                req_dst32,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [ADDR_W-1:0]   req_offset,
   input  logic [IMM_W-1:0]    req_imm,
   input  logic [DATA_W-1:0]   req_wsrc,
   output logic                mem_valid,
   input  logic                mem_ready,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_strb,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                resp_valid,
   output logic [ADDR_W-1:0]   resp_addr,
   output logic                resp_wb_en,
   output logic [ADDR_W-1:0]   resp_wb_val,
   output logic [DATA_W-1:0]   resp_ld_data
);
   localparam int NB     = DATA_W / 8;
   localparam int LANE_W = $clog2(NB);

   generate
      if (DATA_W != 64) begin : g_bad_data_w
         $error("lsu_addr_ext: DATA_W must be 64");
      end
      if (IMM_W < 2 || ADDR_W < IMM_W + LANE_W) begin : g_bad_addr_w
         $error("lsu_addr_ext: ADDR_W too small for IMM_W");
      end
   endgenerate

   lsu_state_e        st;
   logic [ADDR_W-1:0] a_ea;
   logic [ADDR_W-1:0] a_wb;
   logic              a_wben;
   logic [DATA_W-1:0] s_wdata;
   logic [NB-1:0]     s_strb;
   logic [DATA_W-1:0] l_data;

   logic [ADDR_W-1:0] r_ea;
   logic [ADDR_W-1:0] r_wb;
   logic              r_wben;
   logic              r_we;
   logic [NB-1:0]     r_strb;
   logic [DATA_W-1:0] r_wdata;
   asize_e            r_size;
   logic              r_signed;
   logic              r_dst32;
   logic [DATA_W-1:0] r_ld;

   lsu_agen #(
      .ADDR_W    (ADDR_W),
      .IMM_W     (IMM_W),
      .SCALE_UOFF(SCALE_UOFF)
   ) u_agen (
      .base_i  (req_base),
      .offs_i  (req_offset),
      .imm_i   (req_imm),
      .mode_i  (amode_e'(req_mode)),
      .size_i  (asize_e'(req_size)),
      .ea_o    (a_ea),
      .wb_val_o(a_wb),
      .wb_en_o (a_wben)
   );

   lsu_st_fmt #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W)
   ) u_st_fmt (
      .lane_i (a_ea[LANE_W-1:0]),
      .size_i (asize_e'(req_size)),
      .src_i  (req_wsrc),
      .wdata_o(s_wdata),
      .strb_o (s_strb)
   );

   lsu_ld_fmt #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W)
   ) u_ld_fmt (
      .rdata_i (mem_rdata),
      .lane_i  (r_ea[LANE_W-1:0]),
      .size_i  (r_size),
      .signed_i(r_signed),
      .dst32_i (r_dst32),
      .data_o  (l_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         r_ea     <= '0;
         r_wb     <= '0;
         r_wben   <= 1'b0;
         r_we     <= 1'b0;
         r_strb   <= '0;
         r_wdata  <= '0;
         r_size   <= SZ_B;
         r_signed <= 1'b0;
         r_dst32  <= 1'b0;
         r_ld     <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  r_ea     <= a_ea;
                  r_wb     <= a_wb;
                  r_wben   <= a_wben;
                  r_we     <= req_store;
                  r_strb   <= req_store ? s_strb : '0;
                  r_wdata  <= req_store ? s_wdata : '0;
                  r_size   <= asize_e'(req_size);
                  r_signed <= req_signed;
                  r_dst32  <= req_dst32;
                  st       <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (mem_ready) begin
                  r_ld <= r_we ? '0 : l_data;
                  st   <= ST_RESP;
               end
            end
            ST_RESP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (st == ST_IDLE);
   assign mem_valid    = (st == ST_BUSY);
   assign mem_we       = r_we;
   assign mem_addr     = r_ea;
   assign mem_strb     = r_strb;
   assign mem_wdata    = r_wdata;
   assign resp_valid   = (st == ST_RESP);
   assign resp_addr    = r_ea;
   assign resp_wb_en   = r_wben;
   assign resp_wb_val  = r_wb;
   assign resp_ld_data = r_ld;
endmodule

// File: rtl/lsu_addr_ext_chk.sv
module lsu_addr_ext_chk #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [1:0]          req_mode,
   input logic [ADDR_W-1:0]   req_base,
   input logic                mem_valid,
   input logic                mem_ready,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_strb,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                resp_valid,
   input logic [ADDR_W-1:0]   resp_addr,
   input logic                resp_wb_en,
   input logic [ADDR_W-1:0]   resp_wb_val
);
   logic [1:0]        mode_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 2'd0;
         base_q <= '0;
      end else if (req_valid && req_ready) begin
         mode_q <= req_mode;
         base_q <= req_base;
      end
   end

   // R10 and R12: a stalled access keeps its address, strobe and data
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                  && $stable(mem_strb) && $stable(mem_wdata) && $stable(mem_we));

   a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_valid && !req_ready);

   a_r10_resp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready |=> resp_valid);

   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid && req_ready);

   // R1 and R2: the offset modes never write back
   a_r2_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !mode_q[1] |-> !resp_wb_en);

   a_r3_pre_wb: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && mode_q == 2'd2 |-> resp_wb_en && resp_addr == resp_wb_val);

   a_r4_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && mode_q == 2'd3 |-> resp_wb_en && resp_addr == base_q);

   a_r8_strb: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_we |-> mem_strb != '0);

   a_r8_no_strb_load: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_we |-> mem_strb == '0);
endmodule

bind lsu_addr_ext lsu_addr_ext_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/lsu_addr_ext_tb.sv
`timescale 1ns/1ps
module lsu_addr_ext_tb;
   localparam logic [63:0] PAT = 64'h7F80_1234_89AB_CDEF;

   typedef struct packed {
      logic        st;
      logic [1:0]  mode;
      logic [1:0]  size;
      logic        sgn;
      logic        d32;
      logic [63:0] base;
      logic [63:0] offs;
      logic [11:0] imm;
      logic [63:0] src;
      logic [63:0] e_ea;
      logic        e_wben;
      logic [63:0] e_wb;
      logic [63:0] e_val;
      logic [7:0]  e_strb;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 64'h1000, 64'h0, 12'd3,   64'h0, 64'h1018, 1'b0, 64'h0,    PAT,                     8'h00},
      '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 64'h2003, 64'h0, 12'd2,   64'h0, 64'h2005, 1'b0, 64'h0,    64'h12,                  8'h00},
      '{1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 64'h3000, 64'h0, 12'd1,   64'h0, 64'h3002, 1'b0, 64'h0,    64'hFFFF_FFFF_FFFF_89AB, 8'h00},
      '{1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 64'h4000, 64'h4, 12'd5,   64'h0, 64'h4004, 1'b0, 64'h0,    64'h0000_0000_7F80_1234, 8'h00},
      '{1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 64'h4100, 64'h0, 12'd0,   64'h0, 64'h4100, 1'b0, 64'h0,    64'hFFFF_FFFF_89AB_CDEF, 8'h00},
      '{1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 64'h5000, 64'h0, 12'd1,   64'h0, 64'h5001, 1'b1, 64'h5001, 64'h0000_0000_FFFF_FFCD, 8'h00},
      '{1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 64'h6000, 64'h0, 12'hFF0, 64'h0, 64'h6000, 1'b1, 64'h5FF0, 64'h0000_0000_0000_CDEF, 8'h00},
      '{1'b0, 2'd2, 2'd3, 1'b0, 1'b0, 64'h7010, 64'h0, 12'hFF8, 64'h0, 64'h7008, 1'b1, 64'h7008, PAT,                     8'h00},
      '{1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 64'h8000, 64'h0, 12'd3,   64'hAAAA_BBBB_CCCC_1357, 64'h8006, 1'b0, 64'h0,    64'h1357_0000_0000_0000, 8'hC0},
      '{1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 64'h9000, 64'h3, 12'd0,   64'h1122_3344_5566_779A, 64'h9003, 1'b0, 64'h0,    64'h0000_0000_9A00_0000, 8'h08},
      '{1'b1, 2'd3, 2'd2, 1'b0, 1'b0, 64'hA004, 64'h0, 12'd8,   64'hDEAD_BEEF_CAFE_F00D, 64'hA004, 1'b1, 64'hA00C, 64'hCAFE_F00D_0000_0000, 8'hF0},
      '{1'b1, 2'd2, 2'd3, 1'b0, 1'b0, 64'hB000, 64'h0, 12'h010, 64'h0123_4567_89AB_CDEF, 64'hB010, 1'b1, 64'hB010, 64'h0123_4567_89AB_CDEF, 8'hFF},
      '{1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 64'hC000, 64'h0, 12'd0,   64'h0, 64'hC000, 1'b0, 64'h0,    64'h0000_0000_89AB_CDEF, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_store = 1'b0;
   logic [1:0]  req_mode = 2'd0;
   logic [1:0]  req_size = 2'd0;
   logic        req_signed = 1'b0;
   logic        req_dst32 = 1'b0;
   logic [63:0] req_base = '0;
   logic [63:0] req_offset = '0;
   logic [11:0] req_imm = '0;
   logic [63:0] req_wsrc = '0;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic        mem_we;
   logic [63:0] mem_addr;
   logic [7:0]  mem_strb;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata;
   logic        resp_valid;
   logic [63:0] resp_addr;
   logic        resp_wb_en;
   logic [63:0] resp_wb_val;
   logic [63:0] resp_ld_data;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int waitc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign mem_rdata = PAT;

   // memory model: ready after lat waiting cycles
   always @(negedge clk) begin
      if (mem_valid) begin
         if (waitc >= lat) mem_ready = 1'b1;
         else begin
            mem_ready = 1'b0;
            waitc++;
         end
      end else begin
         mem_ready = 1'b0;
         waitc = 0;
      end
   end

   lsu_addr_ext u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_mode(req_mode), .req_size(req_size), .req_signed(req_signed),
      .req_dst32(req_dst32), .req_base(req_base), .req_offset(req_offset),
      .req_imm(req_imm), .req_wsrc(req_wsrc),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_strb(mem_strb), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_wb_en(resp_wb_en),
      .resp_wb_val(resp_wb_val), .resp_ld_data(resp_ld_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string addr_tag(input logic [1:0] m);
      case (m)
         2'd0:    return "R1";
         2'd1:    return "R2";
         2'd2:    return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic string val_tag(input vec_t v);
      if (v.st) return "R8";
      if (v.d32) return "R7/R9";
      if (v.sgn) return "R6/R9";
      return "R5/R9";
   endfunction

   task automatic run(input vec_t v, input int lat_i, input bit junk);
      logic [63:0] c_addr;
      logic [63:0] c_wdata;
      logic [7:0]  c_strb;
      logic        c_we;
      int          nvalid;
      bit          moved;
      lat = lat_i;
      nvalid = 0;
      moved = 1'b0;
      c_addr = '0; c_wdata = '0; c_strb = '0; c_we = 1'b0;
      @(negedge clk);
      req_valid  = 1'b1;
      req_store  = v.st;
      req_mode   = v.mode;
      req_size   = v.size;
      req_signed = v.sgn;
      req_dst32  = v.d32;
      req_base   = v.base;
      req_offset = v.offs;
      req_imm    = v.imm;
      req_wsrc   = v.src;
      @(negedge clk);
      if (junk) begin
         // R12: competing request while the access is in flight
         req_store = ~v.st;
         req_mode  = 2'd1;
         req_base  = 64'hDEAD_0000;
         req_offset = 64'h5;
         req_wsrc  = '1;
      end else begin
         req_valid = 1'b0;
      end
      while (!resp_valid) begin
         if (mem_valid) begin
            if (nvalid == 0) begin
               c_addr = mem_addr; c_wdata = mem_wdata; c_strb = mem_strb; c_we = mem_we;
            end else if (mem_addr != c_addr || mem_wdata != c_wdata || mem_strb != c_strb) begin
               moved = 1'b1;
            end
            nvalid++;
            if (junk && nvalid == 2) req_valid = 1'b0;
         end
         @(negedge clk);
      end
      check(c_addr == v.e_ea, addr_tag(v.mode), "memory address", c_addr, v.e_ea);
      check(resp_addr == v.e_ea, addr_tag(v.mode), "response address", resp_addr, v.e_ea);
      check(resp_wb_en == v.e_wben, addr_tag(v.mode), "write-back enable",
            64'(resp_wb_en), 64'(v.e_wben));
      if (v.e_wben)
         check(resp_wb_val == v.e_wb, addr_tag(v.mode), "write-back value", resp_wb_val, v.e_wb);
      check(c_we == v.st, "R8", "write enable", 64'(c_we), 64'(v.st));
      if (v.st) begin
         check(c_wdata == v.e_val, val_tag(v), "store data", c_wdata, v.e_val);
         check(c_strb == v.e_strb, "R8", "store strobe", 64'(c_strb), 64'(v.e_strb));
      end else begin
         check(resp_ld_data == v.e_val, val_tag(v), "load result", resp_ld_data, v.e_val);
      end
      check(!moved, "R10", "request stable while stalled", 64'(moved), 64'd0);
      check(nvalid == lat_i + 1, "R10", "cycles with request held",
            64'(nvalid), 64'(lat_i + 1));
      @(negedge clk);
      check(!resp_valid && req_ready, "R10", "single-cycle response",
            64'({resp_valid, req_ready}), 64'b01);
   endtask

   task automatic finish_sim();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
      check(mem_valid == 1'b0, "R11", "no memory request after reset", 64'(mem_valid), 64'd0);
      check(resp_valid == 1'b0, "R11", "no response after reset", 64'(resp_valid), 64'd0);

      for (int i = 0; i < NV; i++) run(VEC[i], 0, 1'b0);

      // R10: stalled load and store with a held request
      run(VEC[2], 3, 1'b0);
      run(VEC[10], 2, 1'b0);
      // R12: competing request during a stall is ignored
      run(VEC[5], 3, 1'b1);
      run(VEC[8], 3, 1'b1);
      // R2: immediate ignored in register-offset mode, nonzero offset with lane change
      run(VEC[3], 1, 1'b0);

      repeat (2) @(negedge clk);
      finish_sim();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual=hung expected=complete");
         finish_sim();
      end
   end
endmodule